// File: doc/BRIEF.md
# Dual-Class Interrupt Controller

This block gathers seventeen interrupt requests and drives two processor request outputs: one critical, one non-critical. Seven requests arrive from device pins and are asynchronous. Ten come from on-chip logic that shares the controller clock. Each request has its own settings for active level, detection style (level or edge) and target class. An enable bit decides whether a request may reach its output.

Software reaches the block through a flat register port. Writes are synchronous and reads are combinational. Source index i maps to bit i of every per-source register. Pins `ext_irq[0..6]` are sources 0 to 6, and `int_irq[0..9]` are sources 7 to 16.

The register map is:

| Address | Access | Content |
|---|---|---|
| 0 | read, write-one-to-clear | raw status |
| 1 | read only | pending, which is raw status AND enable |
| 2 | read/write | enable |
| 3 | read/write | mode (1 = edge) |
| 4 | read/write | polarity (1 = active-high) |
| 5 | read/write | class (1 = critical) |
| 6 | read only | critical vector |
| 32+i | read/write | 5-bit rank of source i |

Top module: `dual_class_intc`

## Requirements
- R1: After reset the following read as zero: status, pending, enable, mode, class and every rank. Polarity reads 0x1FFFF, both outputs are low and the vector (address 6) reads 31.
- R2: A level change on a pin source appears in status after the third rising clock edge. A change on an on-chip source appears after the first rising edge.
- R3: With polarity bit 1 a source is active when high. With polarity bit 0 it is active when low.
- R4: In level mode (mode bit 0) the status bit follows the active state of the source, with no latching.
- R5: In edge mode (mode bit 1) an inactive-to-active transition sets a sticky status bit. Writing 1 to that bit at address 0 clears it. Writing 0 leaves it unchanged, and writing 1 to a level-mode bit has no effect.
- R6: A disabled source still shows in raw status. It does not show at address 1 and asserts neither output.
- R7: An enabled, active source drives `crit_irq` when its class bit is 1 and `ncrit_irq` when its class bit is 0.
- R8: The vector holds the index of the enabled, active, critical source with the lowest rank. When ranks are equal, the lower index wins. When no such source exists, the vector reads 31.
- R9: Writing a changed mode or polarity bit clears that source's latched edge status. The change does not set status in the cycles that follow.
- R10: Enable and rank registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| ext_irq | input | 7 | asynchronous pin requests, sources 0..6 |
| int_irq | input | 10 | synchronous on-chip requests, sources 7..16 |
| wr_en | input | 1 | register write strobe |
| addr | input | 6 | register address |
| wdata | input | 17 | write data |
| rdata | output | 17 | read data for `addr` |
| crit_irq | output | 1 | critical request to the processor |
| ncrit_irq | output | 1 | non-critical request to the processor |

## Verification
The assertions assume two things about the inputs. On-chip requests must be stable around the clock edge. The register port must hold address and data steady for the whole cycle in which `wr_en` is high. The bench meets both by changing every input only on the falling clock edge. It also holds each write for exactly one full cycle, so every edge-capture and clear decision is made on clean values.

// File: rtl/dual_class_intc.sv
module dual_class_intc #(
  parameter int N_EXT  = 7,
  parameter int N_INT  = 10,
  parameter int RANK_W = 5,
  parameter int ADDR_W = 6,
  parameter int RANK_BASE = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_EXT-1:0]        ext_irq,
  input  logic [N_INT-1:0]        int_irq,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [N_EXT+N_INT-1:0]  wdata,
  output logic [N_EXT+N_INT-1:0]  rdata,
  output logic                    crit_irq,
  output logic                    ncrit_irq
);
  localparam int N = N_EXT + N_INT;
  localparam int VEC_W = $clog2(N + 1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CLS  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(6);

  logic [N_EXT-1:0] sync1_q, sync2_q;
  logic [N-1:0] en_q, mode_q, pol_q, cls_q;
  logic [N-1:0] smp_q, stat_q, chg_q;
  logic [RANK_W-1:0] rank_q [N];

  logic [N-1:0] raw, qual, edge_hit, chg, clr_m, status, pend, cpend;
  logic [VEC_W-1:0] vec;

  assign raw      = {int_irq, sync2_q};
  assign qual     = ~(raw ^ pol_q);
  assign edge_hit = qual & ~smp_q & ~chg_q & mode_q;

  always_comb begin
    chg = '0;
    if (wr_en && addr == A_MODE) chg = wdata ^ mode_q;
    if (wr_en && addr == A_POL)  chg = wdata ^ pol_q;
  end

  assign clr_m  = chg | ((wr_en && addr == A_STAT) ? wdata : '0);
  assign status = (mode_q & stat_q) | (~mode_q & smp_q);
  assign pend   = status & en_q;
  assign cpend  = pend & cls_q;

  assign crit_irq  = |cpend;
  assign ncrit_irq = |(pend & ~cls_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      smp_q   <= '0;
      stat_q  <= '0;
      chg_q   <= '0;
      en_q    <= '0;
      mode_q  <= '0;
      pol_q   <= '1;
      cls_q   <= '0;
      for (int i = 0; i < N; i++) rank_q[i] <= '0;
    end else begin
      sync1_q <= ext_irq;
      sync2_q <= sync1_q;
      smp_q   <= qual;
      chg_q   <= chg;
      stat_q  <= (stat_q | edge_hit) & ~clr_m;
      if (wr_en) begin
        if (addr == A_EN)   en_q   <= wdata;
        if (addr == A_MODE) mode_q <= wdata;
        if (addr == A_POL)  pol_q  <= wdata;
        if (addr == A_CLS)  cls_q  <= wdata;
        for (int i = 0; i < N; i++)
          if (addr == ADDR_W'(RANK_BASE + i)) rank_q[i] <= wdata[RANK_W-1:0];
      end
    end
  end

  always_comb begin
    logic [RANK_W-1:0] best;
    logic found;
    vec   = '1;
    best  = '1;
    found = 1'b0;
    for (int i = 0; i < N; i++)
      if (cpend[i] && (!found || rank_q[i] < best)) begin
        found = 1'b1;
        best  = rank_q[i];
        vec   = VEC_W'(i);
      end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT: rdata = status;
      A_PEND: rdata = pend;
      A_EN:   rdata = en_q;
      A_MODE: rdata = mode_q;
      A_POL:  rdata = pol_q;
      A_CLS:  rdata = cls_q;
      A_VEC:  rdata = {{(N-VEC_W){1'b0}}, vec};
      default:
        for (int i = 0; i < N; i++)
          if (addr == ADDR_W'(RANK_BASE + i)) rdata = {{(N-RANK_W){1'b0}}, rank_q[i]};
    endcase
  end

  // R8
  crit_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crit_irq == (vec != '1));

  // R8
  vec_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '1) |-> cpend[vec]);

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(stat_q) & ~$past(clr_m)) & ~stat_q) == '0));

  // R9
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & chg_q) == '0);

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!crit_irq && !ncrit_irq));
endmodule

// File: tb/test_dual_class_intc.sv
module test_dual_class_intc;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [6:0] ext_irq = '0;
  logic [9:0] int_irq = '0;
  logic [5:0] addr = '0;
  logic [16:0] wdata = '0, rdata;
  logic crit_irq, ncrit_irq;
  int n_chk = 0, n_bad = 0;

  localparam logic [5:0] A_STAT = 0, A_PEND = 1, A_EN = 2, A_MODE = 3,
                         A_POL = 4, A_CLS = 5, A_VEC = 6;
  localparam int ALL = 17'h1FFFF;

  dual_class_intc i_dual_class_intc (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, output int v);
    @(negedge clk); addr = a; #1; v = int'(rdata);
  endtask

  task automatic wr(logic [5:0] a, int d);
    @(negedge clk); wr_en = 1; addr = a; wdata = 17'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ext_irq = '0; int_irq = '0; wr_en = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_PEND, v); chk("R1 pending", v, 0);
    rd(A_EN, v);   chk("R1 enable", v, 0);
    rd(A_POL, v);  chk("R1 polarity", v, ALL);
    rd(A_VEC, v);  chk("R1 vector", v, 31);
    rd(6'd40, v);  chk("R1 rank", v, 0);
    chk("R1 outputs", {crit_irq, ncrit_irq}, 0);
  endtask

  task automatic t_sync();
    int v;
    do_reset();
    @(negedge clk); ext_irq[0] = 1;
    @(negedge clk);
    rd(A_STAT, v); chk("R2 pin after two edges", v & 1, 0);
    rd(A_STAT, v); chk("R2 pin after three edges", v & 1, 1);
    @(negedge clk); int_irq[0] = 1;
    rd(A_STAT, v); chk("R2 on-chip after one edge", (v >> 7) & 1, 1);
  endtask

  task automatic t_level_pol();
    int v;
    do_reset();
    @(negedge clk); int_irq[0] = 1;
    rd(A_STAT, v); chk("R4 level high", (v >> 7) & 1, 1);
    @(negedge clk); int_irq[0] = 0;
    rd(A_STAT, v); chk("R4 level drops", (v >> 7) & 1, 0);
    wr(A_POL, ALL & ~(1 << 8));
    rd(A_STAT, v); chk("R3 active-low idle input", (v >> 8) & 1, 1);
    @(negedge clk); int_irq[1] = 1;
    rd(A_STAT, v); chk("R3 active-low driven high", (v >> 8) & 1, 0);
  endtask

  task automatic t_edge();
    int v;
    do_reset();
    wr(A_MODE, 1 << 9);
    @(negedge clk); int_irq[2] = 1;
    @(negedge clk); int_irq[2] = 0;
    repeat (2) @(negedge clk);
    rd(A_STAT, v); chk("R5 sticky after pulse", (v >> 9) & 1, 1);
    wr(A_STAT, 0);
    rd(A_STAT, v); chk("R5 write 0 keeps", (v >> 9) & 1, 1);
    wr(A_STAT, 1 << 9);
    rd(A_STAT, v); chk("R5 write 1 clears", (v >> 9) & 1, 0);
    @(negedge clk); int_irq[0] = 1;
    wr(A_STAT, 1 << 7);
    rd(A_STAT, v); chk("R5 level bit ignores clear", (v >> 7) & 1, 1);
  endtask

  task automatic t_en_class();
    int v;
    do_reset();
    @(negedge clk); int_irq[2] = 1;
    rd(A_STAT, v); chk("R6 raw visible", (v >> 9) & 1, 1);
    rd(A_PEND, v); chk("R6 pending hidden", v, 0);
    chk("R6 outputs quiet", {crit_irq, ncrit_irq}, 0);
    wr(A_EN, 1 << 9);
    rd(A_EN, v); chk("R10 enable readback", v, 1 << 9);
    chk("R7 non-critical", {crit_irq, ncrit_irq}, 1);
    wr(A_CLS, 1 << 9);
    #1; chk("R7 critical", {crit_irq, ncrit_irq}, 2);
  endtask

  task automatic t_vector();
    int v;
    do_reset();
    wr(6'd42, 5); wr(6'd43, 3); wr(6'd44, 3);
    rd(6'd43, v); chk("R10 rank readback", v, 3);
    wr(A_CLS, 7 << 10); wr(A_EN, 7 << 10);
    @(negedge clk); int_irq[5:3] = 3'b111;
    rd(A_VEC, v); chk("R8 tie lower index", v, 11);
    wr(6'd43, 7);
    rd(A_VEC, v); chk("R8 lowest rank", v, 12);
    wr(A_EN, 3 << 10);
    rd(A_VEC, v); chk("R8 disabled skipped", v, 10);
    @(negedge clk); int_irq = '0;
    rd(A_VEC, v); chk("R8 none pending", v, 31);
    chk("R8 critical low", crit_irq, 0);
  endtask

  task automatic t_cfgchg();
    int v;
    do_reset();
    wr(A_MODE, 1 << 13);
    @(negedge clk); int_irq[6] = 1;
    rd(A_STAT, v); chk("R9 edge latched", (v >> 13) & 1, 1);
    wr(A_POL, ALL & ~(1 << 13));
    rd(A_STAT, v); chk("R9 polarity change clears", (v >> 13) & 1, 0);
    wr(A_POL, ALL);
    repeat (3) @(negedge clk);
    rd(A_STAT, v); chk("R9 no false edge", (v >> 13) & 1, 0);
    @(negedge clk); int_irq[6] = 0;
    @(negedge clk); int_irq[6] = 1;
    rd(A_STAT, v); chk("R9 true edge still caught", (v >> 13) & 1, 1);
  endtask

  initial begin
    t_reset();
    t_sync();
    t_level_pol();
    t_edge();
    t_en_class();
    t_vector();
    t_cfgchg();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule